// File: doc/BRIEF.md
# Broadcast Storm Monitor with Hysteresis

This block watches the broadcast traffic received on each port of a switch. A per-port counter tallies broadcast frames over fixed time windows. It compares the running count with a rising threshold and the final count with a falling threshold. A per-port storm flag sets as soon as the rising threshold is exceeded and clears only at the end of a quiet window. While a storm is in progress and filtering is enabled, the block flags broadcast frames beyond the rising threshold for discard.

Both thresholds are chosen by 2-bit codes. Each code gives a fraction of a fixed per-window frame maximum. The table changes depending on whether every port runs at 100M. A single alert LED output first reports a memory self-test after reset. After a passing test it shows whether any port is in a storm.

Top module: `bcast_storm_monitor`

## Requirements
- R1: A frame is counted on port p only when `sof_i[p]` and `bcast_i[p]` are both high in the same cycle. Each port keeps its own count. Windows are `WINDOW_CYCLES` clocks long and start at reset release, and the count restarts at zero after every window.
- R2: The rising threshold is floor(`MAX_FRAMES` * m / 1000). When every bit of `port_fast_i` is 1, codes 1/2/3 give m = 100/200/400. Otherwise they give m = 10/20/40.
- R3: The falling threshold uses the same formula. When every bit of `port_fast_i` is 1, codes 1/2/3 give m = 50/100/200. Otherwise they give m = 5/10/20. Code 0 disables the falling threshold.
- R4: When a counted frame brings the window count above the rising threshold, `storm_o[p]` is high from the next cycle.
- R5: At a window end, `storm_o[p]` clears if the final count is below the falling threshold. With the falling code at 0, it clears if the final count did not exceed the rising threshold. Otherwise it stays set.
- R6: A rising code of 0 holds every storm flag clear and suppresses discard.
- R7: `discard_o[p]` is high, in the same cycle as the frame, for a counted frame that arrives when `filter_en_i` is high and the count before that frame is at least the rising threshold. It is low in every other case.
- R8: After reset, `alert_led_o` is on until `LED_HOLD_CYCLES` have elapsed and `bist_done_i` is high.
- R9: After a passing self-test (`bist_pass_i` = 1), `alert_led_o` equals the OR of all storm flags.
- R10: After a failing self-test, `alert_led_o` is off for `FAIL_OFF_CYCLES`, then on until the next reset, whatever the storm flags do.
- R11: During reset, all storm and discard outputs are low and the LED is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | NUM_PORTS | Frame-start strobe per port |
| bcast_i | input | NUM_PORTS | Destination address is all ones, valid with sof_i |
| port_fast_i | input | NUM_PORTS | Port runs at 100M |
| rise_code_i | input | 2 | Rising threshold code |
| fall_code_i | input | 2 | Falling threshold code |
| filter_en_i | input | 1 | Enable discard of excess broadcasts |
| bist_done_i | input | 1 | Memory self-test finished |
| bist_pass_i | input | 1 | Memory self-test result, valid with done |
| storm_o | output | NUM_PORTS | Storm active per port |
| discard_o | output | NUM_PORTS | Discard the current broadcast frame |
| alert_led_o | output | 1 | Alert LED, active high |

## Verification
A corrupt window counter shows up directly at the storm flag. The flag rises one cycle after the frame at the wrong count, so checking the exact frame that crosses the threshold exposes off-by-one errors at once. A wrong window boundary or a hysteresis error only appears at the next window end, as a flag that stays or clears when it should not. Those checks are therefore sampled just after each boundary. A wrong LED sequencer state shows up as the LED level at points chosen well inside each phase of the self-test report.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [1:0] {
    LS_TEST = 2'd0,
    LS_RUN  = 2'd1,
    LS_GAP  = 2'd2,
    LS_FAIL = 2'd3
  } led_state_e;

  // per-mille of the window maximum
  function automatic int rise_permille(input logic [1:0] code, input logic fast);
    int base;
    case (code)
      2'd1:    base = 10;
      2'd2:    base = 20;
      2'd3:    base = 40;
      default: base = 0;
    endcase
    return fast ? base * 10 : base;
  endfunction

  function automatic int fall_permille(input logic [1:0] code, input logic fast);
    int base;
    case (code)
      2'd1:    base = 5;
      2'd2:    base = 10;
      2'd3:    base = 20;
      default: base = 0;
    endcase
    return fast ? base * 10 : base;
  endfunction

  function automatic int scale(input int max_frames, input int permille);
    return (max_frames * permille) / 1000;
  endfunction

endpackage

// File: rtl/bsm_window_timer.sv
module bsm_window_timer #(
  parameter int WINDOW_CYCLES = 2_500_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int WIN_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;

  logic [WIN_W-1:0] cnt_q;

  assign tick_o = (cnt_q == WIN_W'(WINDOW_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_WINDOW_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (cnt_q == '0)); // R1

endmodule

// File: rtl/bsm_port_ctr.sv
module bsm_port_ctr #(
  parameter int CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             tick_i,
  input  logic             rise_en_i,
  input  logic             fall_en_i,
  input  logic [CNT_W-1:0] rise_thr_i,
  input  logic [CNT_W-1:0] fall_thr_i,
  input  logic             filter_en_i,
  output logic             storm_o,
  output logic             discard_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             storm_q, set_storm, quiet_end;

  // saturating count including this cycle's frame
  assign cnt_inc   = (frame_i && (cnt_q != '1)) ? cnt_q + 1'b1 : cnt_q;
  assign set_storm = rise_en_i && frame_i && (cnt_inc > rise_thr_i);
  assign quiet_end = tick_i && (fall_en_i ? (cnt_inc < fall_thr_i)
                                          : (cnt_inc <= rise_thr_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= '0;
    else             cnt_q <= cnt_inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         storm_q <= 1'b0;
    else if (!rise_en_i) storm_q <= 1'b0;
    else if (set_storm)  storm_q <= 1'b1;
    else if (quiet_end)  storm_q <= 1'b0;
  end

  assign storm_o   = storm_q;
  assign discard_o = filter_en_i && rise_en_i && frame_i && (cnt_q >= rise_thr_i);

  AST_RISE_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise_en_i |=> !storm_q); // R6
  AST_SET_NEEDS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(storm_q) |-> $past(frame_i)); // R4
  AST_CLEAR_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(storm_q) |-> $past(tick_i || !rise_en_i)); // R5
  AST_DISCARD_IN_STORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_o |=> storm_q); // R7

endmodule

// File: rtl/bsm_alert_led.sv
module bsm_alert_led
  import bsm_pkg::*;
#(
  parameter int LED_HOLD_CYCLES = 150_000_000,
  parameter int FAIL_OFF_CYCLES = 25_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bist_done_i,
  input  logic bist_pass_i,
  input  logic storm_any_i,
  output logic led_o
);
  localparam int HOLD_MAX = (LED_HOLD_CYCLES > FAIL_OFF_CYCLES) ? LED_HOLD_CYCLES : FAIL_OFF_CYCLES;
  localparam int HOLD_W   = $clog2(HOLD_MAX + 1);

  led_state_e        state_q;
  logic [HOLD_W-1:0] hold_q;
  logic              hold_done, gap_done;

  assign hold_done = (hold_q >= HOLD_W'(LED_HOLD_CYCLES - 1));
  assign gap_done  = (hold_q >= HOLD_W'(FAIL_OFF_CYCLES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LS_TEST;
      hold_q  <= '0;
    end else begin
      case (state_q)
        LS_TEST: begin
          if (!hold_done) hold_q <= hold_q + 1'b1;
          if (hold_done && bist_done_i) begin
            state_q <= bist_pass_i ? LS_RUN : LS_GAP;
            hold_q  <= '0;
          end
        end
        LS_GAP: begin
          hold_q <= hold_q + 1'b1;
          if (gap_done) state_q <= LS_FAIL;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      LS_RUN:  led_o = storm_any_i;
      LS_GAP:  led_o = 1'b0;
      default: led_o = 1'b1;
    endcase
  end

  AST_WAIT_FOR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LS_TEST && !bist_done_i) |=> (state_q == LS_TEST)); // R8
  AST_FAIL_LATCHED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == LS_FAIL) |=> (state_q == LS_FAIL && led_o)); // R10

endmodule

// File: rtl/bcast_storm_monitor.sv
module bcast_storm_monitor
  import bsm_pkg::*;
#(
  parameter int NUM_PORTS       = 26,
  parameter int WINDOW_CYCLES   = 2_500_000,
  parameter int MAX_FRAMES      = 7490,
  parameter int LED_HOLD_CYCLES = 150_000_000,
  parameter int FAIL_OFF_CYCLES = 25_000_000
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] sof_i,
  input  logic [NUM_PORTS-1:0] bcast_i,
  input  logic [NUM_PORTS-1:0] port_fast_i,
  input  logic [1:0]           rise_code_i,
  input  logic [1:0]           fall_code_i,
  input  logic                 filter_en_i,
  input  logic                 bist_done_i,
  input  logic                 bist_pass_i,
  output logic [NUM_PORTS-1:0] storm_o,
  output logic [NUM_PORTS-1:0] discard_o,
  output logic                 alert_led_o
);
  localparam int CNT_W = $clog2(MAX_FRAMES + 1) + 1;

  logic             all_fast, rise_en, fall_en, tick;
  logic [CNT_W-1:0] rise_thr, fall_thr;

  assign all_fast = &port_fast_i;
  assign rise_en  = (rise_code_i != 2'd0);
  assign fall_en  = (fall_code_i != 2'd0);

  always_comb begin
    rise_thr = CNT_W'(scale(MAX_FRAMES, rise_permille(rise_code_i, all_fast)));
    fall_thr = CNT_W'(scale(MAX_FRAMES, fall_permille(fall_code_i, all_fast)));
  end

  bsm_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    bsm_port_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .frame_i     (sof_i[p] && bcast_i[p]),
      .tick_i      (tick),
      .rise_en_i   (rise_en),
      .fall_en_i   (fall_en),
      .rise_thr_i  (rise_thr),
      .fall_thr_i  (fall_thr),
      .filter_en_i (filter_en_i),
      .storm_o     (storm_o[p]),
      .discard_o   (discard_o[p])
    );
  end

  bsm_alert_led #(
    .LED_HOLD_CYCLES (LED_HOLD_CYCLES),
    .FAIL_OFF_CYCLES (FAIL_OFF_CYCLES)
  ) u_led (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bist_done_i (bist_done_i),
    .bist_pass_i (bist_pass_i),
    .storm_any_i (|storm_o),
    .led_o       (alert_led_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> (storm_o == '0 && alert_led_o)); // R11

endmodule

// File: tb/tb_bcast_storm_monitor.sv
`timescale 1ns/1ps
module tb_bcast_storm_monitor;
  localparam int NP = 4;
  localparam int W  = 400;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NP-1:0] sof = '0, bcast = '0, fast = '0;
  logic [1:0]    rise_code = 2'd0, fall_code = 2'd0;
  logic          filter_en = 1'b0, bist_done = 1'b0, bist_pass = 1'b0;
  logic [NP-1:0] storm, discard;
  logic          led;

  int checks = 0, errors = 0, cyc = 0;

  always #2.5 clk = ~clk;

  bcast_storm_monitor #(
    .NUM_PORTS(NP), .WINDOW_CYCLES(W), .MAX_FRAMES(1000),
    .LED_HOLD_CYCLES(50), .FAIL_OFF_CYCLES(20)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .sof_i(sof), .bcast_i(bcast),
    .port_fast_i(fast), .rise_code_i(rise_code), .fall_code_i(fall_code),
    .filter_en_i(filter_en), .bist_done_i(bist_done), .bist_pass_i(bist_pass),
    .storm_o(storm), .discard_o(discard), .alert_led_o(led)
  );

  always @(posedge clk or negedge rst_ni)
    if (!rst_ni) cyc <= 0;
    else         cyc <= cyc + 1;

  task automatic chk(input int act, input int exp, input string msg);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(storm, 0, "R11 storm in reset");
    chk(discard, 0, "R11 discard in reset");
    chk(led, 1, "R11 led in reset");
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic wait_window_start();
    @(negedge clk);
    while (cyc % W != 0) @(negedge clk);
    #1;
  endtask

  task automatic send(input int p, input int n, input logic bc);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      sof[p] = 1'b1;
      bcast[p] = bc;
    end
    @(negedge clk);
    sof = '0;
    bcast = '0;
    #1;
  endtask

  task automatic frame_chk(input int p, input int exp_disc, input string msg);
    @(negedge clk);
    sof[p] = 1'b1;
    bcast[p] = 1'b1;
    #1;
    chk(discard[p], exp_disc, msg);
    @(negedge clk);
    sof = '0;
    bcast = '0;
    #1;
  endtask

  task automatic clear_storms();
    rise_code = 2'd0;
    repeat (2) @(negedge clk);
    #1;
    chk(storm, 0, "R6 rise code 0 clears storms");
    rise_code = 2'd1;
  endtask

  task automatic test_led_fail();
    bist_done = 1'b1; bist_pass = 1'b0;
    do_reset();
    wait_cyc(30); #1; chk(led, 1, "R8 led on during self-test");
    wait_cyc(55); #1; chk(led, 0, "R10 led off after failed test");
    wait_cyc(100); #1; chk(led, 1, "R10 led on after fail gap");
    rise_code = 2'd1; fall_code = 2'd1;
    wait_window_start(); #1;
    chk(led, 1, "R10 led stays on with no storm");
    rise_code = 2'd0; fall_code = 2'd0;
  endtask

  task automatic test_led_pass();
    bist_done = 1'b0; bist_pass = 1'b1;
    do_reset();
    wait_cyc(10); bist_done = 1'b1;
    wait_cyc(30); #1; chk(led, 1, "R8 led held on before hold time");
    wait_cyc(60); #1; chk(led, 0, "R9 led off after pass, no storm");
  endtask

  task automatic test_rise_slow();
    fast = 4'b0111; rise_code = 2'd1; fall_code = 2'd1; filter_en = 1'b1;
    wait_window_start();
    send(1, 20, 1'b0);
    chk(storm[1], 0, "R1 non-broadcast frames not counted");
    send(0, 9, 1'b1);
    frame_chk(0, 0, "R7 frame 10 passes");
    chk(storm[0], 0, "R4 count at threshold no storm");
    frame_chk(0, 1, "R7 frame 11 discarded");
    chk(storm[0], 1, "R4 storm next cycle after exceeding");
    chk(storm[2], 0, "R1 other port unaffected");
    chk(led, 1, "R9 led mirrors storm");
  endtask

  task automatic test_hysteresis();
    wait_window_start();
    chk(storm[0], 1, "R5 storm held after storm window");
    send(0, 7, 1'b1);
    wait_window_start();
    chk(storm[0], 1, "R5 7 frames not below falling 5");
    send(0, 2, 1'b1);
    wait_window_start();
    chk(storm[0], 0, "R5 cleared below falling threshold");
    chk(led, 0, "R9 led off after clear");
  endtask

  task automatic test_filter_off();
    filter_en = 1'b0;
    wait_window_start();
    send(0, 11, 1'b1);
    chk(storm[0], 1, "R4 storm with filter off");
    frame_chk(0, 0, "R7 no discard with filter off");
    filter_en = 1'b1;
    clear_storms();
  endtask

  task automatic test_rise_table();
    fast = 4'b1111; rise_code = 2'd1;
    wait_window_start();
    send(0, 50, 1'b1);
    chk(storm[0], 0, "R2 all-fast code1 threshold 100");
    fast = 4'b0111;
    send(0, 1, 1'b1);
    chk(storm[0], 1, "R2 one slow port threshold 10");
    clear_storms();
    rise_code = 2'd3;
    wait_window_start();
    send(0, 39, 1'b1);
    frame_chk(0, 0, "R7 slow code3 frame 40 passes");
    chk(storm[0], 0, "R2 slow code3 threshold 40");
    frame_chk(0, 1, "R7 slow code3 frame 41 discarded");
    chk(storm[0], 1, "R2 slow code3 exceeded");
    clear_storms();
  endtask

  task automatic test_fall_table();
    fast = 4'b1111; rise_code = 2'd1; fall_code = 2'd1;
    wait_window_start();
    send(2, 101, 1'b1);
    chk(storm[2], 1, "R2 all-fast 101 exceeds 100");
    wait_window_start();
    send(2, 60, 1'b1);
    wait_window_start();
    chk(storm[2], 1, "R3 all-fast 60 not below 50");
    send(2, 40, 1'b1);
    wait_window_start();
    chk(storm[2], 0, "R3 all-fast 40 below 50 clears");
  endtask

  task automatic test_fall_disabled();
    fast = 4'b0111; rise_code = 2'd1; fall_code = 2'd0;
    wait_window_start();
    send(3, 11, 1'b1);
    wait_window_start();
    chk(storm[3], 1, "R5 no falling code, storm window keeps flag");
    send(3, 10, 1'b1);
    wait_window_start();
    chk(storm[3], 0, "R5 no falling code, window at threshold clears");
  endtask

  task automatic test_rise_disabled();
    rise_code = 2'd0; fall_code = 2'd1; filter_en = 1'b1;
    wait_window_start();
    send(0, 49, 1'b1);
    frame_chk(0, 0, "R6 no discard when rising disabled");
    chk(storm[0], 0, "R6 no storm when rising disabled");
  endtask

  initial begin
    test_led_fail();
    test_led_pass();
    test_rise_slow();
    test_hysteresis();
    test_filter_off();
    test_rise_table();
    test_fall_table();
    test_fall_disabled();
    test_rise_disabled();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule